// File: doc/BRIEF.md
# NAND Page Transfer Sequencer

This block runs a raw 8-bit NAND flash device through whole-page read and program operations on its own, so software never drives a strobe. Software loads a page address and strobe timing through a small valid/ready register port. It then writes a start word. The sequencer issues the command byte, the column byte and three row bytes, and then moves the data bytes. For a read, it waits out the device's busy period before the data phase. For a program, it sends a confirm command and waits out the busy period after the data.

Data move between the sequencer and a DMA engine one 32-bit word at a time. A read packs four NAND bytes into a word and requests its removal. A program requests a word and then streams its four bytes to the device. A page is 528 bytes: 512 data bytes followed by a 16-byte spare area. That makes 132 words per operation. Partial pages are not supported. A status register shows whether an operation is running and whether the last one has finished.

Top module: `nand_page_seq`

## Requirements
- R1: After reset all strobes are inactive (`nand_ce_n`, `nand_we_n`, `nand_re_n` high; `nand_cle`, `nand_ale`, `nand_io_oe`, `dma_req` low), the status register reads 0, and the timing register reads 0x22.
- R2: Writing 0x80000000 to register 1 while idle starts a page read. The sequencer sends command byte 0x00 with CLE high, then four bytes with ALE high: address register bits [7:0], [15:8], [23:16], [31:24], in that order.
- R3: Writing 0x40000000 to register 1 while idle starts a page program. The sequencer sends command byte 0x80, the same four address bytes, all page bytes, and then command byte 0x10, each with CLE or ALE set as for a read.
- R4: After the address bytes of a read, no nRE pulse occurs until `nand_rb_n` has gone low and then high again.
- R5: The timing register (register 2) holds the low width in bits [3:0] and the high width in bits [7:4], both in clock cycles. A value of 0 acts as 1. Every nWE and nRE pulse is low for the low width, and consecutive nRE pulses within one word are high for the high width.
- R6: On a read, byte k (0..3) of each group of four lands in `dma_rdata` bits [8k+7:8k]. Each word raises `dma_req`, which stays high until `dma_ack` and drops in the following cycle.
- R7: On a program, each word is fetched with `dma_req`/`dma_ack`. `dma_wdata` is taken in the acknowledge cycle, and its bytes go out lowest byte first.
- R8: Every operation moves exactly 528 bytes (132 words). A read finishes when its last word is acknowledged. A program finishes when the busy period after the confirm command ends.
- R9: The status register (register 3) shows busy in bit 0 and done in bit 1. A start clears done, and completion sets it.
- R10: While an operation runs, writes to the address, timing and command registers have no effect.
- R11: A command word other than the two start words leaves the sequencer idle.
- R12: `nand_ce_n` stays low for a whole operation. CLE and ALE are never high together. `nand_io_oe` is never high while nRE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted (always high) |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 address, 1 command, 2 timing, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the request cycle |
| dma_req | output | 1 | A word is ready (read) or wanted (program) |
| dma_ack | input | 1 | DMA takes or supplies the word this cycle |
| dma_rdata | output | 32 | Packed read word |
| dma_wdata | input | 32 | Word to program |
| nand_ce_n | output | 1 | Device enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb_n | input | 1 | Ready/busy from device, low = busy |
| nand_io_in | input | 8 | Byte from the device |
| nand_io_out | output | 8 | Byte to the device |
| nand_io_oe | output | 1 | Drive enable for `nand_io_out` |

## Verification
A wrong state or a miscounted byte shows up at the very next nWE rising edge. Every latched byte, together with its CLE/ALE flags, is compared in order against the expected command, address and data stream. A packing or lane error shows up in the first DMA word of a read, and a byte-count error shows up as a missing or extra word or pulse by the end of the page. Busy-wait and timing faults show up in the first pulse they touch, through the measured strobe widths and a record of any nRE fall while the device is busy.

// File: rtl/nps_pkg.sv
// Shared types and constants for the NAND page sequencer.
// Assumes a single clock domain for all users.
package nps_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_ADR,            // command and address issue
        ST_RBL, ST_RBH, ST_RDB, ST_RDQ,     // read group
        ST_WRQ, ST_WRB, ST_CFM,             // write group
        ST_PBL, ST_PBH                      // program busy wait
    } nps_state_e;

    localparam logic [1:0]  RA_ADDR = 2'd0;
    localparam logic [1:0]  RA_CMD  = 2'd1;
    localparam logic [1:0]  RA_TIME = 2'd2;
    localparam logic [1:0]  RA_STAT = 2'd3;

    localparam logic [31:0] START_READ = 32'h8000_0000;
    localparam logic [31:0] START_PROG = 32'h4000_0000;

    localparam logic [7:0]  NB_READ    = 8'h00;
    localparam logic [7:0]  NB_PROG    = 8'h80;
    localparam logic [7:0]  NB_CONFIRM = 8'h10;
endpackage

// File: rtl/nps_strobe_timer.sv
// Strobe pulse generator: while run is high it repeats low/high periods
// of programmable length. A length of 0 acts as 1. sample marks the last
// low cycle, fin the last high cycle. Dropping run restarts at low.
module nps_strobe_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] low_len,
    input  logic [TW-1:0] high_len,
    output logic          strobe_n,
    output logic          sample,
    output logic          fin
);
    logic          in_high_q;
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] low_last, high_last;

    // Terminal counts with zero treated as one cycle
    always_comb begin
        low_last  = (low_len  == '0) ? '0 : low_len  - 1'b1;
        high_last = (high_len == '0) ? '0 : high_len - 1'b1;
    end

    // Phase and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            in_high_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!in_high_q) begin
            if (cnt_q == low_last) begin
                in_high_q <= 1'b1;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == high_last) begin
                in_high_q <= 1'b0;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign strobe_n = !(run && !in_high_q);
    assign sample   = run && !in_high_q && (cnt_q == low_last);
    assign fin      = run && in_high_q && (cnt_q == high_last);
endmodule

// File: rtl/nps_word_packer.sv
// Byte-lane word register: a whole word loads from the DMA side, or a
// single byte is written into the lane chosen by sel. The byte at sel is
// also presented for sending. Lane g holds bits [8g+7:8g].
module nps_word_packer #(
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IW-1:0]           sel,
    input  logic                    load,
    input  logic [8*WORD_BYTES-1:0] load_word,
    input  logic                    push,
    input  logic [7:0]              push_byte,
    output logic [8*WORD_BYTES-1:0] word,
    output logic [7:0]              sel_byte
);
    localparam int IW = $clog2(WORD_BYTES);

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        // One lane: whole-word load takes priority over a byte push
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (load)
                lane_q <= load_word[8*g +: 8];
            else if (push && (sel == IW'(g)))
                lane_q <= push_byte;
        end
        assign word[8*g +: 8] = lane_q;
    end

    assign sel_byte = word[8*sel +: 8];
endmodule

// File: rtl/nand_page_seq.sv
// Page sequencer top: register port, operation state machine and NAND pin
// drive. Assumes nand_rb_n is already synchronous to clk and that
// PAGE_BYTES is a multiple of four.
module nand_page_seq
    import nps_pkg::*;
#(
    parameter int PAGE_BYTES = 528,
    parameter int TW         = 4,
    parameter int DEF_LOW    = 2,
    parameter int DEF_HIGH   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_valid,
    output logic        reg_ready,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        dma_req,
    input  logic        dma_ack,
    output logic [31:0] dma_rdata,
    input  logic [31:0] dma_wdata,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    input  logic        nand_rb_n,
    input  logic [7:0]  nand_io_in,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe
);
    localparam int              WORD_BYTES = 4;
    localparam int              ADDR_BYTES = 4;
    localparam int              BCW        = $clog2(PAGE_BYTES + 1);
    localparam logic [BCW-1:0]  BC_END     = BCW'(PAGE_BYTES);
    localparam logic [BCW-1:0]  BC_LAST    = BCW'(PAGE_BYTES - 1);

    nps_state_e     state_q;
    logic [31:0]    addr_q;
    logic [TW-1:0]  low_q, high_q;
    logic           done_q, prog_q;
    logic [1:0]     aidx_q;
    logic [BCW-1:0] bcnt_q;
    logic           busy, wr_en, start_rd, start_pg;
    logic           run, strobe_n, sample, fin, we_phase;
    logic [7:0]     sel_byte;

    assign busy      = (state_q != ST_IDLE);
    assign reg_ready = 1'b1;
    assign wr_en     = reg_valid && reg_wr;
    assign start_rd  = wr_en && !busy && reg_addr == RA_CMD && reg_wdata == START_READ;
    assign start_pg  = wr_en && !busy && reg_addr == RA_CMD && reg_wdata == START_PROG;

    assign we_phase  = state_q inside {ST_CMD, ST_ADR, ST_WRB, ST_CFM};
    assign run       = we_phase || state_q == ST_RDB;

    nps_strobe_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .low_len(low_q), .high_len(high_q),
        .strobe_n(strobe_n), .sample(sample), .fin(fin)
    );

    nps_word_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
        .clk(clk), .rst_n(rst_n), .sel(bcnt_q[1:0]),
        .load(state_q == ST_WRQ && dma_ack), .load_word(dma_wdata),
        .push(state_q == ST_RDB && sample), .push_byte(nand_io_in),
        .word(dma_rdata), .sel_byte(sel_byte)
    );

    // Register file and operation state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            low_q   <= TW'(DEF_LOW);
            high_q  <= TW'(DEF_HIGH);
            done_q  <= 1'b0;
            prog_q  <= 1'b0;
            aidx_q  <= '0;
            bcnt_q  <= '0;
        end else begin
            if (wr_en && !busy && reg_addr == RA_ADDR) addr_q <= reg_wdata;
            if (wr_en && !busy && reg_addr == RA_TIME) {high_q, low_q} <= reg_wdata[2*TW-1:0];
            case (state_q)
                ST_IDLE: if (start_rd || start_pg) begin
                    state_q <= ST_CMD;
                    prog_q  <= start_pg;
                    done_q  <= 1'b0;
                    aidx_q  <= '0;
                    bcnt_q  <= '0;
                end
                ST_CMD: if (fin) state_q <= ST_ADR;
                ST_ADR: if (fin) begin
                    aidx_q <= aidx_q + 1'b1;
                    if (aidx_q == 2'(ADDR_BYTES - 1)) state_q <= prog_q ? ST_WRQ : ST_RBL;
                end
                ST_RBL: if (!nand_rb_n) state_q <= ST_RBH;
                ST_RBH: if (nand_rb_n)  state_q <= ST_RDB;
                ST_RDB: if (fin) begin
                    bcnt_q <= bcnt_q + 1'b1;
                    if (bcnt_q[1:0] == 2'd3) state_q <= ST_RDQ;
                end
                ST_RDQ: if (dma_ack) begin
                    if (bcnt_q == BC_END) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= ST_RDB;
                    end
                end
                ST_WRQ: if (dma_ack) state_q <= ST_WRB;
                ST_WRB: if (fin) begin
                    bcnt_q <= bcnt_q + 1'b1;
                    if (bcnt_q[1:0] == 2'd3) state_q <= (bcnt_q == BC_LAST) ? ST_CFM : ST_WRQ;
                end
                ST_CFM: if (fin) state_q <= ST_PBL;
                ST_PBL: if (!nand_rb_n) state_q <= ST_PBH;
                ST_PBH: if (nand_rb_n) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_valid && !reg_wr) begin
            case (reg_addr)
                RA_ADDR: reg_rdata = addr_q;
                RA_TIME: reg_rdata = 32'({high_q, low_q});
                RA_STAT: reg_rdata = {30'd0, done_q, busy};
                default: reg_rdata = '0;
            endcase
        end
    end

    // NAND pin levels and outgoing byte
    always_comb begin
        nand_ce_n   = !busy;
        nand_cle    = state_q == ST_CMD || state_q == ST_CFM;
        nand_ale    = state_q == ST_ADR;
        nand_we_n   = we_phase ? strobe_n : 1'b1;
        nand_re_n   = (state_q == ST_RDB) ? strobe_n : 1'b1;
        nand_io_oe  = we_phase;
        dma_req     = state_q == ST_RDQ || state_q == ST_WRQ;
        case (state_q)
            ST_CMD:  nand_io_out = prog_q ? NB_PROG : NB_READ;
            ST_ADR:  nand_io_out = addr_q[8*aidx_q +: 8];
            ST_WRB:  nand_io_out = sel_byte;
            ST_CFM:  nand_io_out = NB_CONFIRM;
            default: nand_io_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/nps_checker.sv
// Protocol checker for nand_page_seq, attached by bind below.
module nps_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic dma_req,
    input logic dma_ack,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic io_oe
);
    AST_STROBE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(!re_n && !we_n));                 // R12
    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));                     // R12
    AST_CE_COVERS:    assert property (@(posedge clk) disable iff (!rst_n) (!re_n || !we_n || dma_req) |-> !ce_n); // R12
    AST_NO_CONTEND:   assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !io_oe);                  // R12
    AST_REQ_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (dma_req && !dma_ack) |=> dma_req);  // R6
    AST_REQ_DROP:     assert property (@(posedge clk) disable iff (!rst_n) (dma_req && dma_ack) |=> !dma_req);  // R6
    AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);                    // R9
    AST_START_CMD:    assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (cle && !we_n));     // R2
endmodule

bind nand_page_seq nps_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done_q),
    .dma_req(dma_req), .dma_ack(dma_ack), .ce_n(nand_ce_n),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .io_oe(nand_io_oe)
);

// File: tb/nand_page_seq_tb.sv
// Scoreboard bench: driver tasks queue the expected NAND latch events and
// DMA words; monitors pop and compare them as the design produces them.
module nand_page_seq_tb;
    localparam int PB = 528;
    localparam int NW = PB / 4;
    localparam int BUSY_CYC = 12;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_wr = 1'b0, reg_ready;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        dma_req, dma_ack = 1'b0;
    logic [31:0] dma_rdata, dma_wdata = '0;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic        nand_rb_n = 1'b1, nand_io_oe;
    logic [7:0]  nand_io_in, nand_io_out;

    always #10 clk = ~clk;

    nand_page_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_rdata(dma_rdata), .dma_wdata(dma_wdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb_n(nand_rb_n),
        .nand_io_in(nand_io_in), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    logic [9:0]  nq[$];
    logic [31:0] wq[$];
    string cur_tag = "R2";
    int exp_low = 2, exp_high = 2;
    logic [7:0] seed_m = 8'h00;
    bit prog_mode = 0;
    time we_fall = 0, re_fall = 0, re_rise = 0;
    int rd_total = 0, rd_base = 0, trig = 0, seen = 0, bsy_cnt = 0;
    int ale_cnt = 0, viol = 0, wd_total = 0, ww_total = 0;
    logic [7:0] last_cmd = 8'hFF;
    bit wait_win = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rbyte(input int k, input logic [7:0] s);
        return 8'(k) ^ 8'(k >> 8) ^ s ^ 8'hC3;
    endfunction
    function automatic logic [7:0] pbyte(input int k);
        return 8'(k * 7 + 1);
    endfunction

    // NAND read data model: byte index counts nRE pulses since last command
    assign nand_io_in = !nand_re_n ? rbyte(rd_total - rd_base, seed_m) : 8'h00;

    // Monitor: every nWE rising edge pops one expected latch event
    always @(posedge nand_we_n) if (rst_n) begin
        logic [9:0] ev, e;
        ev = {nand_cle, nand_ale, nand_io_out};
        chk(nand_io_oe, "R12", "io not driven at nWE rise", 32'(nand_io_oe), 1);
        chk((($time - we_fall) / 20) == exp_low, "R5", "nWE low width",
            32'(($time - we_fall) / 20), 32'(exp_low));
        if (nq.size() == 0) chk(0, "R10", "unexpected NAND write", 32'(ev), 0);
        else begin
            e = nq.pop_front();
            chk(ev == e, cur_tag, "NAND latch event", 32'(ev), 32'(e));
        end
        if (nand_cle) begin
            rd_base  = rd_total;
            ale_cnt  = 0;
            last_cmd = nand_io_out;
            if (nand_io_out == 8'h10) trig++;
        end
        if (nand_ale) begin
            ale_cnt++;
            if (ale_cnt == 4 && last_cmd == 8'h00) trig++;
        end
    end
    always @(negedge nand_we_n) we_fall = $time;

    // Monitor: nRE widths and reads during busy
    always @(negedge nand_re_n) if (rst_n) begin
        re_fall = $time;
        if (wait_win) viol++;
        if (((rd_total - rd_base) % 4) != 0)
            chk((($time - re_rise) / 20) == exp_high, "R5", "nRE high width",
                32'(($time - re_rise) / 20), 32'(exp_high));
    end
    always @(posedge nand_re_n) if (rst_n) begin
        chk((($time - re_fall) / 20) == exp_low, "R5", "nRE low width",
            32'(($time - re_fall) / 20), 32'(exp_low));
        re_rise = $time;
        rd_total++;
    end

    // NAND busy model: R/nB low for BUSY_CYC cycles after each trigger
    always @(negedge clk) begin
        if (!rst_n) begin
            nand_rb_n = 1'b1;
        end else if (trig != seen) begin
            seen = trig;
            nand_rb_n = 1'b0;
            bsy_cnt = BUSY_CYC;
            wait_win = 1;
        end else if (bsy_cnt > 0) begin
            bsy_cnt--;
            if (bsy_cnt == 0) begin
                nand_rb_n = 1'b1;
                wait_win = 0;
            end
        end
    end

    // DMA responder and read-word monitor
    always @(negedge clk) begin
        if (!rst_n) dma_ack = 1'b0;
        else if (dma_ack) dma_ack = 1'b0;
        else if (dma_req) begin
            chk(!nand_ce_n, "R8", "device enabled while words pending", 32'(nand_ce_n), 0);
            if (prog_mode) begin
                dma_wdata = {pbyte(4*ww_total+3), pbyte(4*ww_total+2),
                             pbyte(4*ww_total+1), pbyte(4*ww_total)};
                ww_total++;
            end else begin
                if (wq.size() == 0) chk(0, "R8", "extra read word", dma_rdata, 0);
                else begin
                    logic [31:0] e;
                    e = wq.pop_front();
                    chk(dma_rdata == e, "R6", "packed read word", dma_rdata, e);
                end
                wd_total++;
            end
            dma_ack = 1'b1;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_wr = 0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1; reg_wr = 0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        s = 0;
        for (int i = 0; i < 20000 && !s[1]; i++) reg_read(2'd3, s);
        chk(s == 32'h2, req, "status after completion", s, 32'h2);
    endtask

    // Driver: queue the expected events of a page read
    task automatic push_read(input logic [31:0] a);
        cur_tag = "R2";
        nq.push_back({2'b10, 8'h00});
        for (int i = 0; i < 4; i++) nq.push_back({2'b01, a[8*i +: 8]});
        seed_m = a[15:8];
        for (int w = 0; w < NW; w++)
            wq.push_back({rbyte(4*w+3, seed_m), rbyte(4*w+2, seed_m),
                          rbyte(4*w+1, seed_m), rbyte(4*w, seed_m)});
    endtask

    // Driver: queue the expected events of a page program
    task automatic push_prog(input logic [31:0] a);
        cur_tag = "R3";
        nq.push_back({2'b10, 8'h80});
        for (int i = 0; i < 4; i++) nq.push_back({2'b01, a[8*i +: 8]});
        for (int k = 0; k < PB; k++) nq.push_back({2'b00, pbyte(k)});
        nq.push_back({2'b10, 8'h10});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(0, "ALL", "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int w0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state
        chk({nand_ce_n, nand_we_n, nand_re_n} == 3'b111, "R1", "strobes idle",
            32'({nand_ce_n, nand_we_n, nand_re_n}), 7);
        chk({nand_cle, nand_ale, nand_io_oe, dma_req} == 4'b0, "R1", "enables low",
            32'({nand_cle, nand_ale, nand_io_oe, dma_req}), 0);
        reg_read(2'd3, d); chk(d == 0, "R1", "status after reset", d, 0);
        reg_read(2'd2, d); chk(d == 32'h22, "R1", "timing after reset", d, 32'h22);

        // R11: unknown command word
        reg_write(2'd1, 32'h1234_5678);
        repeat (20) @(negedge clk);
        chk(nand_ce_n, "R11", "idle after unknown command", 32'(nand_ce_n), 1);
        reg_read(2'd3, d); chk(d == 0, "R11", "status after unknown command", d, 0);

        // R2 R4 R6 R8 R9 R10: read with default timing, writes while busy
        reg_write(2'd0, 32'h0312_A505);
        push_read(32'h0312_A505);
        w0 = wd_total;
        reg_write(2'd1, 32'h8000_0000);
        reg_read(2'd3, d); chk(d == 32'h1, "R9", "busy after start", d, 1);
        reg_write(2'd0, 32'hDEAD_BEEF);
        reg_write(2'd2, 32'h0000_0055);
        reg_write(2'd1, 32'h4000_0000);
        wait_done("R8");
        chk(nq.size() == 0, "R2", "all command/address events seen", nq.size(), 0);
        chk(wq.size() == 0, "R6", "all read words delivered", wq.size(), 0);
        chk(wd_total - w0 == NW, "R8", "read word count", wd_total - w0, NW);
        chk(viol == 0, "R4", "nRE while device busy", viol, 0);
        reg_read(2'd0, d); chk(d == 32'h0312_A505, "R10", "address unchanged", d, 32'h0312_A505);
        reg_read(2'd2, d); chk(d == 32'h22, "R10", "timing unchanged", d, 32'h22);
        repeat (40) @(negedge clk);
        chk(nand_ce_n, "R10", "no operation from ignored start", 32'(nand_ce_n), 1);

        // R3 R5 R7 R8 R9: program with low=3, high=1
        reg_write(2'd2, 32'h13);
        exp_low = 3; exp_high = 1;
        reg_write(2'd0, 32'h0001_4000);
        prog_mode = 1;
        push_prog(32'h0001_4000);
        w0 = ww_total;
        reg_write(2'd1, 32'h4000_0000);
        reg_read(2'd3, d); chk(d == 32'h1, "R9", "start clears done", d, 1);
        wait_done("R8");
        chk(nq.size() == 0, "R7", "all program bytes latched", nq.size(), 0);
        chk(ww_total - w0 == NW, "R7", "program word count", ww_total - w0, NW);
        prog_mode = 0;

        // R5 R2: zero timing acts as one cycle
        reg_write(2'd2, 32'h00);
        exp_low = 1; exp_high = 1;
        reg_write(2'd0, 32'h00FF_7F00);
        push_read(32'h00FF_7F00);
        reg_write(2'd1, 32'h8000_0000);
        wait_done("R8");
        chk(nq.size() == 0 && wq.size() == 0, "R5", "fast read complete",
            nq.size() + wq.size(), 0);
        chk(viol == 0, "R4", "nRE while device busy", viol, 0);
        chk(nand_ce_n && !nand_io_oe, "R12", "pins idle after operation",
            32'({nand_ce_n, nand_io_oe}), 2);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule